// File: doc/BRIEF.md
# Seven-to-one serial lane transmitter with pixel splitting

This block turns a 28-bit parallel pixel word into serial form for a display link. Each channel has four data lanes and a forwarded clock lane. Every lane carries seven bits per word. The whole block runs on one fast clock `clk`, and a clock enable `bit_en` marks each serial bit time. The pixel clock `pclk` comes in as a plain level. It is sampled on `clk`, and words are taken on its rising or falling transition, as the edge-select input picks.

A 2-bit configuration code picks one of four modes:

- One channel fed from one input bus.
- Two channels fed by splitting one input stream into alternate pixels. The first pixel after data-enable rises goes to channel A.
- Two channels fed from two input buses.
- A reserved code that keeps everything off.

An 18-bit colour option switches off the top lane of each active channel; that lane reports a high-impedance state. A channel the mode does not use is reported as powered off, and that takes priority over the high-impedance state. A low power enable stops the serializer and forces every output low.

Every lane has a 2-bit status output so that the analog driver stage can be steered. A swing-select bit is registered through to the driver side.

Top module: `ser7_tx`

## Requirements
- R1: While `rst` is high or `pwr_en` is low (one clock later for `pwr_en`), every serial output, clock lane, status field and `swing_out` is 0 (status 00 = off). The word holding stages and the pixel phase are cleared, so the first slot after power-up carries an all-zero word unless a capture came before the boundary.
- R2: Mode codes are:
  - `mode`=00: channel A carries `din_a` and channel B is off.
  - `mode`=01: channel A and channel B are both fed from `din_a`.
  - `mode`=10: channel A carries `din_a` and channel B carries `din_b`.
  - `mode`=11 (reserved): both channels are off and all their outputs are low.
- R3: Lane l of a slot carries word bits [7l+6:7l] (the default bit map), and bit 7l is sent first. Word bit 26 is the data-enable flag.
- R4: An active channel's clock lane is high for the first 4 bit times of every 7-bit slot and low for the last 3. The clock lane is 1 only while that channel's lane-0 status is active.
- R5: A slot counter advances on `bit_en`. New words load only on the slot boundary edge, which is the first enabled edge after power-up and then every 7 enabled edges. Each slot carries the latest word captured on a `clk` edge before its boundary edge, and bit 0 appears right after that edge.
- R6: `pclk` is sampled on `clk`. A capture happens on the first `clk` edge that sees `pclk` at its new level: a rise when `edge_rise`=1, a fall when `edge_rise`=0. Changes of the data inputs at other edges have no effect.
- R7: With `depth18`=1, lane 3 of each active channel reports status 10 (high impedance) and drives 0, so input bits 27:21 of that channel are ignored. Lanes 0 to 2 stay active.
- R8: A channel unused by the mode reports status 00 (off), never 10, even with `depth18`=1. Its data and clock lanes drive 0.
- R9: In `mode`=01, a captured pixel goes to channel A if its data-enable is 1 and the previous captured pixel's data-enable was 0, or if the previous pixel went to channel B. Otherwise it goes to channel B.
- R10: While `bit_en` is low and the configuration is unchanged, the serial outputs and clock lanes hold their values.
- R11: Status fields are 2 bits per lane (00 off, 01 active, 10 high impedance), lane l at bits [2l+1:2l]. They follow the configuration one `clk` later.
- R12: `swing_out` equals `swing_in` AND `pwr_en`, one `clk` later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one serial bit per enabled edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Serial bit-time clock enable |
| pclk | input | 1 | Pixel clock level, sampled on `clk` |
| edge_rise | input | 1 | 1 = capture on pixel clock rise, 0 = on fall |
| pwr_en | input | 1 | 1 = running, 0 = powered down |
| mode | input | 2 | Channel configuration code |
| depth18 | input | 1 | 1 = 18-bit colour, top lane high impedance |
| swing_in | input | 1 | Output swing select request |
| din_a | input | 28 | First pixel input bus |
| din_b | input | 28 | Second pixel input bus |
| ser_a | output | 4 | Channel A serial data lanes |
| ck_a | output | 1 | Channel A forwarded clock lane |
| st_a | output | 8 | Channel A lane status, 2 bits per lane |
| ser_b | output | 4 | Channel B serial data lanes |
| ck_b | output | 1 | Channel B forwarded clock lane |
| st_b | output | 8 | Channel B lane status, 2 bits per lane |
| swing_out | output | 1 | Registered swing select |

## Verification
Results fall due at three different times:

- Status fields, `swing_out` and the power-down forcing change one `clk` after the configuration. The bench checks them every cycle against the values it drove before that edge.
- A capture lands on the `clk` edge after the bench moves `pclk`. The bench keeps its own model of the holding stages and updates it at that edge, after it has used the old values for any slot that starts on the same edge.
- Slot data appears from the boundary edge onward, one bit per `clk`. The bench finds each boundary from the rise of the forwarded clock and gathers seven samples. It then compares the whole word and the 4/3 clock shape against the model value taken at the boundary.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

  localparam int LANES_DEF = 4;
  localparam int SLOT_DEF  = 7;
  localparam int IDX_W_DEF = 5;
  localparam int WORD_DEF  = LANES_DEF * SLOT_DEF;
  localparam int MAP_W_DEF = WORD_DEF * IDX_W_DEF;

  typedef enum logic [1:0] {
    LST_OFF = 2'b00,
    LST_ON  = 2'b01,
    LST_HIZ = 2'b10
  } lane_st_e;

  typedef enum logic [1:0] {
    CFG_SS  = 2'b00,
    CFG_SD  = 2'b01,
    CFG_DD  = 2'b10,
    CFG_RSV = 2'b11
  } cfg_e;

  // Lane-major default: slot bit k of lane l takes word bit l*SLOT+k.
  function automatic logic [MAP_W_DEF-1:0] lane_major_map();
    logic [MAP_W_DEF-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_DEF; i++) begin
      m[i*IDX_W_DEF +: IDX_W_DEF] = IDX_W_DEF'(i);
    end
    return m;
  endfunction

endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
  parameter int WORD_W = 28,
  parameter int DE_POS = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_en,
  input  logic              pclk,
  input  logic              edge_rise,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] din_a,
  input  logic [WORD_W-1:0] din_b,
  output logic [WORD_W-1:0] hold_a,
  output logic [WORD_W-1:0] hold_b
);
  import ser7_pkg::*;

  logic pclk_q;
  logic phase_q;   // 1: next split pixel goes to channel B
  logic de_q;      // data-enable of last captured pixel
  logic edge_hit;
  logic to_first;

  always_comb begin
    edge_hit = edge_rise ? (pclk && !pclk_q) : (!pclk && pclk_q);
    to_first = (din_a[DE_POS] && !de_q) || !phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_q  <= 1'b0;
      phase_q <= 1'b0;
      de_q    <= 1'b0;
      hold_a  <= '0;
      hold_b  <= '0;
    end else begin
      pclk_q <= pclk;
      if (!pwr_en) begin
        phase_q <= 1'b0;
        de_q    <= 1'b0;
        hold_a  <= '0;
        hold_b  <= '0;
      end else if (edge_hit) begin
        de_q <= din_a[DE_POS];
        case (cfg_e'(mode))
          CFG_SD: begin
            if (to_first) begin
              hold_a  <= din_a;
              phase_q <= 1'b1;
            end else begin
              hold_b  <= din_a;
              phase_q <= 1'b0;
            end
          end
          CFG_DD: begin
            hold_a <= din_a;
            hold_b <= din_b;
          end
          default: hold_a <= din_a;
        endcase
      end
    end
  end

endmodule

// File: rtl/ser7_ctrl.sv
module ser7_ctrl #(
  parameter int LANES   = 4,
  parameter int SLOT    = 7,
  parameter int CK_HIGH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_en,
  input  logic                        pwr_en,
  input  logic [1:0]                  mode,
  input  logic                        depth18,
  output logic                        load,
  output logic [1:0][LANES-1:0]       lane_act,
  output logic [1:0]                  ck_q,
  output logic [1:0][LANES-1:0][1:0]  st_q
);
  import ser7_pkg::*;

  localparam int CNT_W = $clog2(SLOT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT - 1);
  localparam logic [CNT_W-1:0] CKH  = CNT_W'(CK_HIGH);

  logic [CNT_W-1:0]            cnt_q;
  logic [CNT_W-1:0]            cnt_nxt;
  logic [1:0]                  chan_on;
  logic [1:0][LANES-1:0][1:0]  st_nxt;

  always_comb begin
    chan_on[0] = pwr_en && (cfg_e'(mode) != CFG_RSV);
    chan_on[1] = pwr_en && ((cfg_e'(mode) == CFG_SD) || (cfg_e'(mode) == CFG_DD));
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      for (int l = 0; l < LANES; l++) begin
        lane_act[c][l] = chan_on[c] && !((l == LANES-1) && depth18);
        if (!chan_on[c])                        st_nxt[c][l] = LST_OFF;
        else if ((l == LANES-1) && depth18)     st_nxt[c][l] = LST_HIZ;
        else                                    st_nxt[c][l] = LST_ON;
      end
    end
  end

  always_comb begin
    cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    load    = pwr_en && bit_en && (cnt_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_en) begin
      cnt_q <= LAST;
    end else if (bit_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      ck_q <= '0;
    end else begin
      st_q <= st_nxt;
      for (int c = 0; c < 2; c++) begin
        if (!chan_on[c])  ck_q[c] <= 1'b0;
        else if (bit_en)  ck_q[c] <= (cnt_nxt < CKH);
      end
    end
  end

endmodule

// File: rtl/ser7_chan.sv
module ser7_chan #(
  parameter int LANES = 4,
  parameter int SLOT  = 7,
  parameter int IDX_W = 5,
  parameter logic [LANES*SLOT*IDX_W-1:0] BIT_MAP = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pwr_en,
  input  logic                    bit_en,
  input  logic                    load,
  input  logic [LANES-1:0]        lane_act,
  input  logic [LANES*SLOT-1:0]   word,
  output logic [LANES-1:0]        ser
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOT-1:0] slot_bits;
    logic [SLOT-1:0] sreg;
    logic            dout;

    for (genvar k = 0; k < SLOT; k++) begin : g_bit
      assign slot_bits[k] = word[BIT_MAP[(l*SLOT+k)*IDX_W +: IDX_W]];
    end

    always_ff @(posedge clk) begin
      if (rst || !pwr_en) begin
        sreg <= '0;
      end else if (bit_en) begin
        sreg <= load ? slot_bits : {1'b0, sreg[SLOT-1:1]};
      end
    end

    always_ff @(posedge clk) begin
      if (rst || !lane_act[l]) begin
        dout <= 1'b0;
      end else if (bit_en) begin
        dout <= load ? slot_bits[0] : sreg[1];
      end
    end

    assign ser[l] = dout;
  end

endmodule

// File: rtl/ser7_tx.sv
module ser7_tx #(
  parameter int LANES   = ser7_pkg::LANES_DEF,
  parameter int SLOT    = ser7_pkg::SLOT_DEF,
  parameter int CK_HIGH = 4,
  parameter int DE_POS  = 26,
  parameter int IDX_W   = ser7_pkg::IDX_W_DEF,
  parameter logic [LANES*SLOT*IDX_W-1:0] BIT_MAP = ser7_pkg::lane_major_map()
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_en,
  input  logic                   pclk,
  input  logic                   edge_rise,
  input  logic                   pwr_en,
  input  logic [1:0]             mode,
  input  logic                   depth18,
  input  logic                   swing_in,
  input  logic [LANES*SLOT-1:0]  din_a,
  input  logic [LANES*SLOT-1:0]  din_b,
  output logic [LANES-1:0]       ser_a,
  output logic                   ck_a,
  output logic [2*LANES-1:0]     st_a,
  output logic [LANES-1:0]       ser_b,
  output logic                   ck_b,
  output logic [2*LANES-1:0]     st_b,
  output logic                   swing_out
);

  localparam int WORD_W = LANES * SLOT;

  logic [1:0][WORD_W-1:0]        hold;
  logic                          load;
  logic [1:0][LANES-1:0]         lane_act;
  logic [1:0]                    ck_q;
  logic [1:0][LANES-1:0][1:0]    st_q;
  logic [1:0][LANES-1:0]         ser_q;
  logic                          swing_q;

  ser7_capture #(.WORD_W(WORD_W), .DE_POS(DE_POS)) u_cap (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .pclk(pclk), .edge_rise(edge_rise),
    .mode(mode), .din_a(din_a), .din_b(din_b),
    .hold_a(hold[0]), .hold_b(hold[1])
  );

  ser7_ctrl #(.LANES(LANES), .SLOT(SLOT), .CK_HIGH(CK_HIGH)) u_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_en(pwr_en), .mode(mode),
    .depth18(depth18), .load(load), .lane_act(lane_act), .ck_q(ck_q), .st_q(st_q)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    ser7_chan #(.LANES(LANES), .SLOT(SLOT), .IDX_W(IDX_W), .BIT_MAP(BIT_MAP)) u_chan (
      .clk(clk), .rst(rst), .pwr_en(pwr_en), .bit_en(bit_en), .load(load),
      .lane_act(lane_act[c]), .word(hold[c]), .ser(ser_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) swing_q <= 1'b0;
    else     swing_q <= swing_in && pwr_en;
  end

  assign ser_a     = ser_q[0];
  assign ser_b     = ser_q[1];
  assign ck_a      = ck_q[0];
  assign ck_b      = ck_q[1];
  assign st_a      = st_q[0];
  assign st_b      = st_q[1];
  assign swing_out = swing_q;

endmodule

// File: rtl/ser7_tx_chk.sv
module ser7_tx_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bit_en,
  input logic                 pwr_en,
  input logic [1:0]           mode,
  input logic                 depth18,
  input logic [LANES-1:0]     ser_a,
  input logic                 ck_a,
  input logic [2*LANES-1:0]   st_a,
  input logic [LANES-1:0]     ser_b,
  input logic                 ck_b,
  input logic [2*LANES-1:0]   st_b,
  input logic                 swing_out
);

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (ser_a == '0 && ser_b == '0 && !ck_a && !ck_b &&
                 st_a == '0 && st_b == '0 && !swing_out));

  a_r2_rsv_quiet: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && mode == 2'b11) |=> (ser_a == '0 && ser_b == '0 && !ck_a && !ck_b &&
                                   st_a == '0 && st_b == '0));

  a_r8_unused_off: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && mode == 2'b00) |=> (st_b == '0 && ser_b == '0 && !ck_b));

  a_r7_top_hiz: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && mode != 2'b11 && depth18) |=>
      (st_a[2*LANES-1 -: 2] == 2'b10 && !ser_a[LANES-1]));

  a_r4_ck_owner: assert property (@(posedge clk) disable iff (rst)
    ck_a |-> (st_a[1:0] == 2'b01));

  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && pwr_en && $past(pwr_en) && $stable(mode) && $stable(depth18)) |=>
      ($stable(ser_a) && $stable(ser_b) && $stable(ck_a) && $stable(ck_b)));

endmodule

bind ser7_tx ser7_tx_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_en(pwr_en), .mode(mode),
  .depth18(depth18), .ser_a(ser_a), .ck_a(ck_a), .st_a(st_a), .ser_b(ser_b),
  .ck_b(ck_b), .st_b(st_b), .swing_out(swing_out)
);

// File: tb/ser7_tx_tb.sv
module ser7_tx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b1;
  logic        pclk = 1'b0;
  logic        edge_rise = 1'b1;
  logic        pwr_en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        depth18 = 1'b0;
  logic        swing_in = 1'b0;
  logic [27:0] din_a = '0;
  logic [27:0] din_b = '0;
  logic [3:0]  ser_a, ser_b;
  logic        ck_a, ck_b, swing_out;
  logic [7:0]  st_a, st_b;

  int total = 0;
  int bad   = 0;

  // bench model of the holding stages
  logic [27:0] ea = '0, eb = '0;
  bit          ph = 0, dep = 0;
  logic        pclk_prev = 1'b0;
  int          pp = 0;

  // slot monitor state
  logic [27:0] got [2];
  logic [27:0] expw [2];
  int          idx [2];
  bit          ckok [2];
  bit          prevck [2];
  bit          mon_on = 0;

  always #10 clk = ~clk;

  ser7_tx u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pclk(pclk), .edge_rise(edge_rise),
    .pwr_en(pwr_en), .mode(mode), .depth18(depth18), .swing_in(swing_in),
    .din_a(din_a), .din_b(din_b), .ser_a(ser_a), .ck_a(ck_a), .st_a(st_a),
    .ser_b(ser_b), .ck_b(ck_b), .st_b(st_b), .swing_out(swing_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_st(input int c);
    logic [7:0] s;
    bit on;
    on = pwr_en && mode != 2'b11 && (c == 0 || mode == 2'b01 || mode == 2'b10);
    for (int l = 0; l < 4; l++) begin
      if (!on)                      s[2*l +: 2] = 2'b00;
      else if (l == 3 && depth18)   s[2*l +: 2] = 2'b10;
      else                          s[2*l +: 2] = 2'b01;
    end
    return s;
  endfunction

  task automatic monitor();
    for (int c = 0; c < 2; c++) begin
      logic [3:0] s;
      logic       k;
      logic [7:0] st, es;
      bit         on;
      s  = c ? ser_b : ser_a;
      k  = c ? ck_b : ck_a;
      st = c ? st_b : st_a;
      es = exp_st(c);
      on = es[1:0] == 2'b01;
      // R11 status encoding, R7 top lane, R8 unused channel off, R2 reserved off
      chk(st == es, c ? "R11/R8 status B" : "R11/R7 status A", {24'd0, st}, {24'd0, es});
      if (!on) begin
        chk(s == 4'd0 && !k, c ? "R8/R1 B quiet" : "R2/R1 A quiet", {27'd0, k, s}, 32'd0);
        idx[c] = 0;
      end else if (depth18) begin
        chk(!s[3], "R7 lane3 low", {31'd0, s[3]}, 32'd0);
      end
      if (mon_on && on) begin
        if (k && !prevck[c]) begin
          idx[c]  = 1;
          expw[c] = c ? eb : ea;
          got[c]  = '0;
          ckok[c] = 1;
          for (int l = 0; l < 4; l++) got[c][l*7] = s[l];
        end else if (idx[c] > 0 && idx[c] < 7) begin
          for (int l = 0; l < 4; l++) got[c][l*7 + idx[c]] = s[l];
          if (k != (idx[c] < 4)) ckok[c] = 0;
          idx[c]++;
          if (idx[c] == 7) begin
            logic [27:0] e;
            e = depth18 ? (expw[c] & 28'h01FFFFF) : expw[c];
            // R3 lane layout, R5 slot content, R9 split, R6 edge
            chk(got[c] == e, c ? "R5/R9/R3 slot B" : "R5/R6/R3 slot A", {4'd0, got[c]}, {4'd0, e});
            chk(ckok[c], "R4 clock shape", {31'd0, ckok[c]}, 32'd1);
            idx[c] = 0;
          end
        end
      end
      prevck[c] = k;
    end
    chk(swing_out == (swing_in && pwr_en), "R12 swing", {31'd0, swing_out}, {31'd0, swing_in && pwr_en});
  endtask

  task automatic model_apply();
    bit edge_hit;
    edge_hit = edge_rise ? (pclk && !pclk_prev) : (!pclk && pclk_prev);
    if (!pwr_en) begin
      ea = '0; eb = '0; ph = 0; dep = 0;
    end else if (edge_hit) begin
      if (mode == 2'b01) begin
        if ((din_a[26] && !dep) || !ph) begin ea = din_a; ph = 1; end
        else begin eb = din_a; ph = 0; end
      end else if (mode == 2'b10) begin
        ea = din_a; eb = din_b;
      end else begin
        ea = din_a;
      end
      dep = din_a[26];
    end
    pclk_prev = pclk;
  endtask

  task automatic drive();
    bit [6:0] pat;
    pat = (mode == 2'b01) ? 7'b0010011 : 7'b0001111;
    pp = (pp + 1) % 7;
    pclk     = pat[pp];
    din_a    = 28'($urandom());
    din_b    = 28'($urandom());
    swing_in = 1'($urandom());
  endtask

  task automatic cyc();
    @(negedge clk);
    monitor();
    model_apply();
    drive();
  endtask

  task automatic run_cfg(input logic [1:0] m, input bit d18, input bit re, input int n);
    pwr_en = 1'b0;
    mon_on = 0;
    repeat (3) cyc();
    mode = m; depth18 = d18; edge_rise = re;
    repeat (2) cyc();
    pwr_en = 1'b1;
    mon_on = 1;
    repeat (n) cyc();
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL R5 watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      idx[c] = 0; prevck[c] = 0; ckok[c] = 1; got[c] = '0; expw[c] = '0;
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ser_a == 0 && ser_b == 0 && !ck_a && !ck_b && st_a == 0 && st_b == 0 && !swing_out,
        "R1 reset", {18'd0, st_a, ser_a, ck_a, ck_b}, 32'd0);
    rst = 1'b0;

    run_cfg(2'b00, 0, 1, 140);   // single in / single out, rising edge
    run_cfg(2'b00, 1, 0, 140);   // 18-bit, falling edge
    run_cfg(2'b01, 0, 1, 160);   // split, rising
    run_cfg(2'b01, 1, 0, 160);   // split, 18-bit, falling
    run_cfg(2'b10, 0, 0, 140);   // dual in, falling
    run_cfg(2'b10, 1, 1, 140);   // dual in, 18-bit, rising
    run_cfg(2'b11, 1, 1, 40);    // reserved: all off

    // R10: freeze with bit_en low mid-slot
    run_cfg(2'b10, 0, 1, 45);
    begin
      logic [9:0] snap;
      snap   = {ser_a, ser_b, ck_a, ck_b};
      mon_on = 0;
      bit_en = 1'b0;
      repeat (5) begin
        cyc();
        chk({ser_a, ser_b, ck_a, ck_b} == snap, "R10 freeze",
            {22'd0, ser_a, ser_b, ck_a, ck_b}, {22'd0, snap});
      end
      bit_en = 1'b1;
    end

    // R1: power-down mid-run forces quiet outputs (checked by monitor)
    run_cfg(2'b01, 0, 0, 60);
    pwr_en = 1'b0;
    mon_on = 0;
    repeat (4) cyc();
    chk(ser_a == 0 && ser_b == 0 && !ck_a && !ck_b && st_a == 0 && st_b == 0,
        "R1 power down", {22'd0, ser_a, ser_b, ck_a, ck_b}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule